// File: doc/BRIEF.md
# Square-Wave Periodic Timer with Count Latch

This block is a 16-bit down-counter that advances only on cycles where an external tick-enable input is high. In square-wave operation it counts from a programmed reload value to zero. On the tick after zero it reloads and inverts an output pin. The pin therefore toggles once per reload interval, and a full output cycle spans two intervals. A reload value of N gives a half-period of N+1 ticks. Each high-to-low transition of the pin sets an interrupt flag. An enable bit can route that flag onto an active-low interrupt output.

A host reaches the block over a byte-wide register bus with a 2-bit address. A status register at address 0 is visible in every bank. Its top two bits choose which bank appears at the other addresses, and bit 5 holds the interrupt flag. To read the running count without tearing, the host issues a latch command, then reads the high byte and then the low byte. Reading the low byte releases the latch. The counter keeps running while the latch is held.

Top module: `sqw_timer`

## Requirements
- R1: A synchronous reset clears the count, the reload value, GO, the mode bit, the bank select, the interrupt enable and the interrupt flag, and drives `wave_out` high and `irq_n` high. After reset, a status read returns 0x00.
- R2: In bank 0, address 2 writes the high byte and address 3 writes the low byte of the reload value. A write of control bit 0 (GO) that changes GO from 0 to 1 loads the counter from the reload value. The output half-period is then N+1 ticks.
- R3: While running, `wave_out` inverts at each reload (the tick that finds the count at zero). A full output period is 2(N+1) ticks.
- R4: The interrupt flag (status bit 5) is set on a high-to-low change of `wave_out`. A low-to-high change does not set it.
- R5: A status write with bit 5 at 1 clears the flag. A status write with bit 5 at 0 leaves the flag unchanged. Every status write loads bits 7:6 into the bank select.
- R6: `irq_n` is low exactly while the flag is set and the enable bit is set. The enable bit is bit 7 of the register at address 1 in bank 1.
- R7: The control register is at address 1 in bank 0. Bit 2 selects square-wave mode and bit 0 is GO. The count moves only when both bits are set and `tick_en` is high. Writing 0x04 arms the timer without starting it.
- R8: A control write with bit 6 set captures the current count into a hold register. Reads of addresses 2 and 3 return that held value while the counter goes on counting.
- R9: A read of address 3 in bank 0 releases the latch. After that, the hold register follows the live count again, one cycle behind.
- R10: Clearing GO stops counting. The count and the `wave_out` level keep their values.
- R11: The bank select controls which registers respond. Bank 0 shows control, high and low count. Bank 1 shows the interrupt enable at address 1. In banks 2 and 3, addresses 1 to 3 read 0x00 and writes to them are ignored.
- R12: A reload value written while the timer runs takes effect at the next reload and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | External count tick enable |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for latch release) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from address and bank) |
| wave_out | output | 1 | Square-wave output, high after reset |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The hardest situation to reach is a latched read that takes place while the counter is demonstrably still moving. Two things must be shown together: the held bytes stay frozen across reads made many cycles apart, and the live count is lower once the low-byte read releases the latch. The stimulus starts a reload of 1000 with a tick on every cycle and issues the latch command. It reads the high byte twice, 30 cycles apart, then reads the low byte and reads the count again. The flag tests need similar care. The bench waits for a real falling edge of the pin, then clears the flag. It then waits for the rising edge, so that it can show that only the falling edge sets the flag.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    // Register addresses (2-bit bus)
    localparam logic [1:0] REG_STAT   = 2'd0;
    localparam logic [1:0] REG_CTRL   = 2'd1;
    localparam logic [1:0] REG_CNT_HI = 2'd2;
    localparam logic [1:0] REG_CNT_LO = 2'd3;

    // Bit positions
    localparam int STAT_FLAG_BIT = 5;
    localparam int CTL_GO_BIT    = 0;
    localparam int CTL_MODE_BIT  = 2;
    localparam int CTL_LATCH_BIT = 6;
    localparam int IE_BIT        = 7;

    typedef enum logic [1:0] {
        BANK_TIMER = 2'b00,
        BANK_IRQ   = 2'b01,
        BANK_RSV2  = 2'b10,
        BANK_RSV3  = 2'b11
    } bank_e;

    typedef struct packed {
        logic mode;
        logic go;
    } ctl_t;

    function automatic logic [7:0] ctl_readback(ctl_t c);
        logic [7:0] r;
        r = 8'h00;
        r[CTL_MODE_BIT] = c.mode;
        r[CTL_GO_BIT]   = c.go;
        return r;
    endfunction

    function automatic logic [7:0] stat_readback(bank_e b, logic flag);
        return {b, flag, 5'b0};
    endfunction

endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
    import sqw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [CNT_W-1:0] hold,
    input  logic             fall_evt,
    output logic [CNT_W-1:0] reload,
    output ctl_t             ctl,
    output logic             start,
    output logic             latch_cmd,
    output logic             latch_rel,
    output logic             ie,
    output logic             flag
);
    localparam int HI_W = CNT_W - 8;

    bank_e bank;
    logic  in_timer, in_irq;
    logic  wr_stat, wr_ctrl, wr_ie, wr_hi, wr_lo;

    assign in_timer = (bank == BANK_TIMER);
    assign in_irq   = (bank == BANK_IRQ);
    assign wr_stat  = wr_en && (addr == REG_STAT);
    assign wr_ctrl  = wr_en && (addr == REG_CTRL)   && in_timer;
    assign wr_ie    = wr_en && (addr == REG_CTRL)   && in_irq;
    assign wr_hi    = wr_en && (addr == REG_CNT_HI) && in_timer;
    assign wr_lo    = wr_en && (addr == REG_CNT_LO) && in_timer;

    assign start     = wr_ctrl && wdata[CTL_GO_BIT] && !ctl.go;
    assign latch_cmd = wr_ctrl && wdata[CTL_LATCH_BIT];
    assign latch_rel = rd_en && (addr == REG_CNT_LO) && in_timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank   <= BANK_TIMER;
            flag   <= 1'b0;
            ctl    <= '0;
            ie     <= 1'b0;
            reload <= '0;
        end else begin
            if (wr_stat)
                bank <= bank_e'(wdata[7:6]);
            if (fall_evt)
                flag <= 1'b1;
            else if (wr_stat && wdata[STAT_FLAG_BIT])
                flag <= 1'b0;
            if (wr_ctrl) begin
                ctl.mode <= wdata[CTL_MODE_BIT];
                ctl.go   <= wdata[CTL_GO_BIT];
            end
            if (wr_ie)
                ie <= wdata[IE_BIT];
            if (wr_hi)
                reload[CNT_W-1:8] <= wdata[HI_W-1:0];
            if (wr_lo)
                reload[7:0] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == REG_STAT) begin
            rdata = stat_readback(bank, flag);
        end else if (in_timer) begin
            case (addr)
                REG_CTRL:   rdata = ctl_readback(ctl);
                REG_CNT_HI: rdata = 8'(hold >> 8);
                REG_CNT_LO: rdata = hold[7:0];
                default:    rdata = 8'h00;
            endcase
        end else if (in_irq && addr == REG_CTRL) begin
            rdata[IE_BIT] = ie;
        end
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> flag);
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[STAT_FLAG_BIT] && !fall_evt) |=> !flag);
    // R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> $stable(bank));

endmodule

// File: rtl/sqw_core.sv
module sqw_core
    import sqw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  ctl_t             ctl,
    input  logic             start,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wave,
    output logic             fall_evt
);
    logic run, expire;

    assign run      = ctl.go && ctl.mode;
    assign expire   = run && tick_en && (cnt == '0) && !start;
    assign fall_evt = expire && wave;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b1;
        end else if (start) begin
            cnt <= reload;
        end else if (run && tick_en) begin
            if (cnt == '0) begin
                cnt  <= reload;
                wave <= ~wave;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (wave && cnt == '0));
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == $past(reload)));
    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (wave != $past(wave)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> ($stable(cnt) && $stable(wave)));

endmodule

// File: rtl/sqw_latch.sv
module sqw_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             latch_cmd,
    input  logic             latch_rel,
    output logic [CNT_W-1:0] hold
);
    logic frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold   <= '0;
            frozen <= 1'b0;
        end else if (latch_cmd) begin
            hold   <= cnt;
            frozen <= 1'b1;
        end else if (latch_rel) begin
            hold   <= cnt;
            frozen <= 1'b0;
        end else if (!frozen) begin
            hold <= cnt;
        end
    end

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !latch_cmd && !latch_rel) |=> $stable(hold));

endmodule

// File: rtl/sqw_timer.sv
module sqw_timer
    import sqw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wave_out,
    output logic       irq_n
);
    logic [CNT_W-1:0] reload, cnt, hold;
    ctl_t ctl;
    logic start, latch_cmd, latch_rel, ie, flag, fall_evt;

    sqw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .hold(hold), .fall_evt(fall_evt),
        .reload(reload), .ctl(ctl), .start(start), .latch_cmd(latch_cmd),
        .latch_rel(latch_rel), .ie(ie), .flag(flag)
    );

    sqw_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ctl(ctl), .start(start),
        .reload(reload), .cnt(cnt), .wave(wave_out), .fall_evt(fall_evt)
    );

    sqw_latch #(.CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst(rst), .cnt(cnt), .latch_cmd(latch_cmd),
        .latch_rel(latch_rel), .hold(hold)
    );

    assign irq_n = ~(flag & ie);

    // R6
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> flag);

endmodule

// File: tb/sqw_timer_test.sv
module sqw_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wave_out, irq_n;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    logic tick_on = 1'b0;
    int tcnt = 0;

    sqw_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .wave_out(wave_out),
        .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tcnt++;
        tick_en = tick_on && ((tcnt % tick_div) == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_true(input string req, input bit c, input int act, input int exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_count(output int v);
        logic [7:0] h, l;
        bus_rd(2'd2, h);
        bus_rd(2'd3, l);
        v = {h, l};
    endtask

    task automatic do_reset(input int div);
        @(negedge clk);
        rst = 1'b1; tick_on = 1'b0; tick_div = div;
        repeat (3) @(negedge clk);
        rst = 1'b0; tick_on = 1'b1;
    endtask

    task automatic set_reload(input int n);
        bus_wr(2'd2, 8'(n >> 8));
        bus_wr(2'd3, 8'(n));
    endtask

    task automatic wait_level(input logic v);
        do @(negedge clk); while (wave_out != v);
    endtask

    // sync to a toggle, then count cycles spanning k further toggles
    task automatic span(input int k, output int n);
        logic prev;
        wait_level(~wave_out);
        n = 0;
        for (int i = 0; i < k; i++) begin
            prev = wave_out;
            do begin @(negedge clk); n++; end while (wave_out == prev);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int v;
        do_reset(1);
        bus_rd(2'd0, d);
        chk("R1 status after reset", d, 8'h00);
        chk("R1 wave after reset", wave_out, 1);
        chk("R1 irq_n after reset", irq_n, 1);
        read_count(v);
        chk("R1 count after reset", v, 0);
    endtask

    task automatic t_period;
        int n;
        do_reset(1);
        set_reload(3);
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd1, 8'h05);
        span(1, n);
        chk("R2 half period N=3", n, 4);
        span(2, n);
        chk("R3 full period N=3", n, 8);
        do_reset(3);
        set_reload(9);
        bus_wr(2'd1, 8'h05);
        span(1, n);
        chk("R7 half period N=9 tick every 3rd cycle", n, 30);
    endtask

    task automatic t_armed;
        int v;
        do_reset(1);
        set_reload(5);
        bus_wr(2'd1, 8'h04);
        repeat (20) @(negedge clk);
        chk("R7 armed 0x04 keeps wave high", wave_out, 1);
        read_count(v);
        chk("R7 armed 0x04 does not count", v, 0);
    endtask

    task automatic t_flag;
        logic [7:0] d;
        do_reset(1);
        bus_wr(2'd0, 8'h40);
        bus_wr(2'd1, 8'h80);
        bus_rd(2'd1, d);
        chk("R11 bank1 enable readback", d, 8'h80);
        bus_wr(2'd0, 8'h00);
        set_reload(7);
        bus_wr(2'd1, 8'h05);
        wait_level(1'b1);
        wait_level(1'b0);
        bus_rd(2'd0, d);
        chk("R4 flag set on falling edge", d, 8'h20);
        chk("R6 irq_n low with flag and enable", irq_n, 0);
        bus_wr(2'd0, 8'h20);
        bus_rd(2'd0, d);
        chk("R5 write bit5 clears flag, bank 00 kept", d, 8'h00);
        chk("R6 irq_n high after clear", irq_n, 1);
        wait_level(1'b1);
        bus_rd(2'd0, d);
        chk("R4 rising edge leaves flag clear", d, 8'h00);
        wait_level(1'b0);
        bus_wr(2'd0, 8'h40);
        bus_rd(2'd0, d);
        chk("R5 write without bit5 keeps flag, sets bank 01", d, 8'h60);
        bus_wr(2'd1, 8'h00);
        chk("R6 irq_n high with enable cleared", irq_n, 1);
        bus_rd(2'd1, d);
        chk("R11 bank1 enable cleared readback", d, 8'h00);
    endtask

    task automatic t_latch;
        logic [7:0] h1, h2, l1;
        int v, v2, w1, w2;
        logic wv;
        do_reset(1);
        set_reload(1000);
        bus_wr(2'd1, 8'h05);
        repeat (50) @(negedge clk);
        bus_wr(2'd1, 8'h45);
        bus_rd(2'd2, h1);
        repeat (30) @(negedge clk);
        bus_rd(2'd2, h2);
        chk("R8 held high byte stable", h2, h1);
        bus_rd(2'd3, l1);
        v = {h1, l1};
        chk_true("R8 held count in range", (v < 1000) && (v > 900), v, 950);
        repeat (5) @(negedge clk);
        read_count(v2);
        chk_true("R9 live count after release", v2 < v - 30, v2, v - 40);
        // stop and show hold of count and level
        bus_wr(2'd1, 8'h04);
        wv = wave_out;
        bus_wr(2'd1, 8'h44);
        read_count(w1);
        repeat (40) @(negedge clk);
        bus_wr(2'd1, 8'h44);
        read_count(w2);
        chk("R10 count held when GO cleared", w2, w1);
        chk("R10 wave held when GO cleared", wave_out, wv);
    endtask

    task automatic t_bank;
        logic [7:0] d;
        bus_wr(2'd0, 8'h80);
        bus_rd(2'd0, d);
        chk("R11 status shows bank 2", d, 8'h80);
        bus_wr(2'd1, 8'h05);
        bus_rd(2'd1, d);
        chk("R11 bank2 reads zero", d, 8'h00);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd1, d);
        chk("R11 bank2 write ignored, control intact", d, 8'h04);
    endtask

    task automatic t_reload_change;
        int n;
        do_reset(1);
        set_reload(3);
        bus_wr(2'd1, 8'h05);
        span(1, n);
        set_reload(7);
        span(1, n);
        chk("R12 new reload used at next reload", n, 8);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_period();
        t_armed();
        t_flag();
        t_latch();
        t_bank();
        t_reload_change();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule